// File: doc/BRIEF.md
# I2C Controller FIFO Level Unit

This block holds the two data queues of an I2C controller: a transmit queue of 10-bit command words, which software fills and the bus engine empties, and a receive queue of 8-bit bytes, which the bus engine fills and software empties. Each queue holds 16 entries. The bus-side byte engine is outside the block. It appears only as a pop strobe on the transmit side and a push strobe on the receive side.

Software sees occupancy counts, a status byte, a receive threshold that it can program, and a control bit that flushes the transmit queue and holds it empty. Three level conditions go to an interrupt latch outside the block: transmit empty, transmit half empty and receive threshold reached. Occupancy and the threshold both use zero-based values. A threshold of 3 means four bytes, and an occupancy of 3 means four entries when the queue is not empty.

Top module: `i2c_fifo_level_unit`

## Requirements
- R1: After reset both queues are empty, both occupancies read 0, the threshold reads 0, the status byte is 8'hC0, irqTxEmpty and irqTxHalf are 1 and irqRxFull is 0.
- R2: Each queue returns its entries in the order they were written, and holds up to 16 of them.
- R3: An occupancy output reads N-1 when its queue holds N entries (N from 1 to 16). It reads 0 when the queue is empty.
- R4: Status byte fields: bit 7 means the transmit queue is empty, bit 6 the receive queue is empty, bit 5 the receive queue holds 16 entries, bit 4 the transmit queue holds 16 entries. Bits 3 to 0 are 0.
- R5: A push to a full queue and a pop from an empty queue are ignored. Occupancy and stored contents stay unchanged.
- R6: A push and a pop in the same cycle both take effect on a partly filled queue. On a full queue only the pop takes effect, and on an empty queue only the push.
- R7: Writing 1 to the transmit-flush control bit empties the transmit queue on that clock edge. While the bit stays 1, transmit pushes and pops are ignored. Writing 0 releases the queue. The receive queue is not affected.
- R8: The receive threshold is a 4-bit zero-based register that resets to 0. irqRxFull is 1 exactly when the receive queue holds at least threshold+1 entries.
- R9: irqTxEmpty is 1 when the transmit queue holds 0 entries. irqTxHalf is 1 when it holds 8 entries or fewer.
- R10: Reading the receive data repeatedly until status bit 6 sets removes every stored byte, and the count of reads equals the number of stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txWrEn | input | 1 | Software write of one transmit command word |
| txWrData | input | 10 | Transmit command word |
| rxRdEn | input | 1 | Software read strobe; removes the receive head |
| rxRdData | output | 8 | Receive head byte, valid while not empty |
| ctlWrEn | input | 1 | Write strobe for the flush control bit |
| ctlTxRst | input | 1 | Flush control value written by ctlWrEn |
| thrWrEn | input | 1 | Write strobe for the receive threshold |
| thrWrData | input | 4 | Zero-based receive threshold |
| thrValue | output | 4 | Current receive threshold |
| engTxPop | input | 1 | Bus engine takes the transmit head |
| engTxData | output | 10 | Transmit head word |
| engRxPush | input | 1 | Bus engine delivers one received byte |
| engRxData | input | 8 | Received byte |
| txOcc | output | 4 | Zero-based transmit occupancy |
| rxOcc | output | 4 | Zero-based receive occupancy |
| statusFlags | output | 8 | Empty and full flags |
| irqTxEmpty | output | 1 | Transmit queue empty condition |
| irqTxHalf | output | 1 | Transmit queue half-empty condition |
| irqRxFull | output | 1 | Receive threshold reached condition |

## Verification
The assertions check on every cycle how the status flags, occupancy outputs and interrupt levels agree with each other. They also check that a push into a full queue or a read from an empty one leaves the flags and occupancy unchanged, and that a flush write leaves the transmit queue empty after the next edge. Some behaviour needs a known history of writes, and only the directed scenarios show it: data order through both queues, the threshold firing exactly at threshold+1 bytes, the half-empty boundary between 8 and 9 entries, the dropped word when a push and a pop meet a full queue, and stale words being discarded by a flush.

// File: rtl/flu_pkg.sv
package flu_pkg;
  // Strobes from control to datapath; each is already qualified.
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
  } fluStrobes_t;
endpackage

// File: rtl/flu_fifo.sv
module flu_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [CW-1:0]    count
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // Storage carries no reset; only the pointers define validity.
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/flu_datapath.sv
module flu_datapath
  import flu_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned TX_WIDTH = 10,
  parameter int unsigned RX_WIDTH = 8,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  fluStrobes_t         strobes,
  input  logic [TX_WIDTH-1:0] txWrData,
  input  logic [RX_WIDTH-1:0] rxWrData,
  output logic [TX_WIDTH-1:0] txHead,
  output logic [RX_WIDTH-1:0] rxHead,
  output logic [CW-1:0]       txCount,
  output logic [CW-1:0]       rxCount
);
  flu_fifo #(.DEPTH(DEPTH), .WIDTH(TX_WIDTH)) u_txFifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobes.txPush),
    .pop    (strobes.txPop),
    .flush  (strobes.txFlush),
    .wrData (txWrData),
    .rdData (txHead),
    .count  (txCount)
  );

  flu_fifo #(.DEPTH(DEPTH), .WIDTH(RX_WIDTH)) u_rxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobes.rxPush),
    .pop    (strobes.rxPop),
    .flush  (1'b0),
    .wrData (rxWrData),
    .rdData (rxHead),
    .count  (rxCount)
  );
endmodule

// File: rtl/flu_ctrl.sv
module flu_ctrl
  import flu_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned HALF_LEVEL = DEPTH / 2,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          txWrEn,
  input  logic          rxRdEn,
  input  logic          ctlWrEn,
  input  logic          ctlTxRst,
  input  logic          thrWrEn,
  input  logic [AW-1:0] thrWrData,
  input  logic          engTxPop,
  input  logic          engRxPush,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  output fluStrobes_t   strobes,
  output logic [AW-1:0] thrValue,
  output logic [AW-1:0] txOcc,
  output logic [AW-1:0] rxOcc,
  output logic [7:0]    statusFlags,
  output logic          irqTxEmpty,
  output logic          irqTxHalf,
  output logic          irqRxFull
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(HALF_LEVEL);

  logic txRstHeld;
  logic txRstEff;
  logic txFull, txEmpty, rxFull, rxEmpty;

  function automatic logic [AW-1:0] zeroBased(input logic [CW-1:0] c);
    logic [CW-1:0] m;
    m = (c == '0) ? '0 : c - CW'(1);
    return m[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRstHeld <= 1'b0;
      thrValue  <= '0;
    end else begin
      if (ctlWrEn) txRstHeld <= ctlTxRst;
      if (thrWrEn) thrValue  <= thrWrData;
    end
  end

  // A flush write acts on the same edge that stores it.
  assign txRstEff = ctlWrEn ? ctlTxRst : txRstHeld;

  assign txFull  = (txCount == FULL_CNT);
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == FULL_CNT);
  assign rxEmpty = (rxCount == '0);

  always_comb begin
    strobes         = '0;
    strobes.txFlush = txRstEff;
    strobes.txPush  = txWrEn   && !txFull  && !txRstEff;
    strobes.txPop   = engTxPop && !txEmpty && !txRstEff;
    strobes.rxPush  = engRxPush && !rxFull;
    strobes.rxPop   = rxRdEn    && !rxEmpty;
  end

  assign txOcc = zeroBased(txCount);
  assign rxOcc = zeroBased(rxCount);

  assign statusFlags = {txEmpty, rxEmpty, rxFull, txFull, 4'b0000};

  assign irqTxEmpty = txEmpty;
  assign irqTxHalf  = (txCount <= HALF_CNT);
  assign irqRxFull  = (rxCount >= ({1'b0, thrValue} + CW'(1)));
endmodule

// File: rtl/i2c_fifo_level_unit.sv
module i2c_fifo_level_unit
  import flu_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned TX_WIDTH = 10,
  parameter int unsigned RX_WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txWrEn,
  input  logic [TX_WIDTH-1:0] txWrData,
  input  logic                rxRdEn,
  output logic [RX_WIDTH-1:0] rxRdData,
  input  logic                ctlWrEn,
  input  logic                ctlTxRst,
  input  logic                thrWrEn,
  input  logic [AW-1:0]       thrWrData,
  output logic [AW-1:0]       thrValue,
  input  logic                engTxPop,
  output logic [TX_WIDTH-1:0] engTxData,
  input  logic                engRxPush,
  input  logic [RX_WIDTH-1:0] engRxData,
  output logic [AW-1:0]       txOcc,
  output logic [AW-1:0]       rxOcc,
  output logic [7:0]          statusFlags,
  output logic                irqTxEmpty,
  output logic                irqTxHalf,
  output logic                irqRxFull
);
  fluStrobes_t   strobes;
  logic [CW-1:0] txCount;
  logic [CW-1:0] rxCount;

  flu_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txWrEn      (txWrEn),
    .rxRdEn      (rxRdEn),
    .ctlWrEn     (ctlWrEn),
    .ctlTxRst    (ctlTxRst),
    .thrWrEn     (thrWrEn),
    .thrWrData   (thrWrData),
    .engTxPop    (engTxPop),
    .engRxPush   (engRxPush),
    .txCount     (txCount),
    .rxCount     (rxCount),
    .strobes     (strobes),
    .thrValue    (thrValue),
    .txOcc       (txOcc),
    .rxOcc       (rxOcc),
    .statusFlags (statusFlags),
    .irqTxEmpty  (irqTxEmpty),
    .irqTxHalf   (irqTxHalf),
    .irqRxFull   (irqRxFull)
  );

  flu_datapath #(.DEPTH(DEPTH), .TX_WIDTH(TX_WIDTH), .RX_WIDTH(RX_WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txWrData (txWrData),
    .rxWrData (engRxData),
    .txHead   (engTxData),
    .rxHead   (rxRdData),
    .txCount  (txCount),
    .rxCount  (rxCount)
  );
endmodule

// File: rtl/flu_checker.sv
module flu_checker #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          txWrEn,
  input logic          rxRdEn,
  input logic          ctlWrEn,
  input logic          ctlTxRst,
  input logic          engTxPop,
  input logic          engRxPush,
  input logic [AW-1:0] txOcc,
  input logic [AW-1:0] rxOcc,
  input logic [7:0]    statusFlags,
  input logic          irqTxEmpty,
  input logic          irqTxHalf,
  input logic          irqRxFull
);
  localparam logic [AW-1:0] MAX_OCC = '1;

  p_low_bits_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[3:0] == 4'b0000);

  p_tx_full_occ_r4: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[4] |-> txOcc == MAX_OCC);

  p_rx_full_occ_r4: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[5] |-> rxOcc == MAX_OCC);

  p_tx_empty_occ_r3: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[7] |-> txOcc == '0);

  p_rx_empty_occ_r3: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[6] |-> rxOcc == '0);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[4] && txWrEn && !engTxPop && !ctlWrEn
    |=> statusFlags[4] && $stable(txOcc));

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[6] && rxRdEn && !engRxPush |=> statusFlags[6]);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn && ctlTxRst |=> statusFlags[7]);

  p_empty_is_half_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqTxEmpty |-> irqTxHalf);

  p_full_not_half_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[4] |-> !irqTxHalf);

  p_rxfull_implies_thr_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusFlags[5] |-> irqRxFull);

  p_thr_needs_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqRxFull |-> !statusFlags[6]);
endmodule

bind i2c_fifo_level_unit flu_checker #(.AW(AW)) u_fluChecker (
  .clk         (clk),
  .rstN        (rstN),
  .txWrEn      (txWrEn),
  .rxRdEn      (rxRdEn),
  .ctlWrEn     (ctlWrEn),
  .ctlTxRst    (ctlTxRst),
  .engTxPop    (engTxPop),
  .engRxPush   (engRxPush),
  .txOcc       (txOcc),
  .rxOcc       (rxOcc),
  .statusFlags (statusFlags),
  .irqTxEmpty  (irqTxEmpty),
  .irqTxHalf   (irqTxHalf),
  .irqRxFull   (irqRxFull)
);

// File: tb/i2c_fifo_level_unit_bench.sv
`timescale 1ns/1ps
module i2c_fifo_level_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txWrEn = 1'b0;
  logic [9:0] txWrData = '0;
  logic       rxRdEn = 1'b0;
  logic [7:0] rxRdData;
  logic       ctlWrEn = 1'b0;
  logic       ctlTxRst = 1'b0;
  logic       thrWrEn = 1'b0;
  logic [3:0] thrWrData = '0;
  logic [3:0] thrValue;
  logic       engTxPop = 1'b0;
  logic [9:0] engTxData;
  logic       engRxPush = 1'b0;
  logic [7:0] engRxData = '0;
  logic [3:0] txOcc, rxOcc;
  logic [7:0] statusFlags;
  logic       irqTxEmpty, irqTxHalf, irqRxFull;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  i2c_fifo_level_unit u_i2c_fifo_level_unit (
    .clk(clk), .rstN(rstN), .txWrEn(txWrEn), .txWrData(txWrData),
    .rxRdEn(rxRdEn), .rxRdData(rxRdData), .ctlWrEn(ctlWrEn),
    .ctlTxRst(ctlTxRst), .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .thrValue(thrValue), .engTxPop(engTxPop), .engTxData(engTxData),
    .engRxPush(engRxPush), .engRxData(engRxData), .txOcc(txOcc),
    .rxOcc(rxOcc), .statusFlags(statusFlags), .irqTxEmpty(irqTxEmpty),
    .irqTxHalf(irqTxHalf), .irqRxFull(irqRxFull)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic txPush(input logic [9:0] d);
    txWrEn = 1'b1; txWrData = d; tick(); txWrEn = 1'b0;
  endtask

  task automatic txPop(output logic [9:0] d);
    d = engTxData; engTxPop = 1'b1; tick(); engTxPop = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] d);
    engRxPush = 1'b1; engRxData = d; tick(); engRxPush = 1'b0;
  endtask

  task automatic rxRead(output logic [7:0] d);
    d = rxRdData; rxRdEn = 1'b1; tick(); rxRdEn = 1'b0;
  endtask

  task automatic setThr(input logic [3:0] t);
    thrWrEn = 1'b1; thrWrData = t; tick(); thrWrEn = 1'b0;
  endtask

  task automatic ctlWrite(input logic v);
    ctlWrEn = 1'b1; ctlTxRst = v; tick(); ctlWrEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "txOcc", txOcc, 0);
    check("R1", "rxOcc", rxOcc, 0);
    check("R1", "status", statusFlags, 8'hC0);
    check("R1", "thr", thrValue, 0);
    check("R1", "irqTxEmpty", irqTxEmpty, 1);
    check("R1", "irqTxHalf", irqTxHalf, 1);
    check("R1", "irqRxFull", irqRxFull, 0);
  endtask

  task automatic t_tx_fill();
    logic [9:0] d;
    for (int i = 0; i < 16; i++) begin
      txPush(10'h200 + 10'(i));
      if (i == 0) begin
        check("R3", "one entry occ", txOcc, 0);
        check("R4", "one entry not empty", statusFlags[7], 0);
        check("R9", "one entry irqTxEmpty", irqTxEmpty, 0);
      end
      if (i == 7) check("R9", "8 entries half", irqTxHalf, 1);
      if (i == 8) check("R9", "9 entries half", irqTxHalf, 0);
    end
    check("R4", "tx full status", statusFlags, 8'h50);
    check("R3", "full occ", txOcc, 15);
    txPush(10'h3FF);
    check("R5", "push to full occ", txOcc, 15);
    for (int i = 0; i < 16; i++) begin
      txPop(d);
      check("R2", "tx order", d, 10'h200 + 10'(i));
    end
    check("R4", "tx drained status", statusFlags, 8'hC0);
    check("R9", "drained irqTxEmpty", irqTxEmpty, 1);
    txPop(d);
    check("R5", "pop empty occ", txOcc, 0);
    check("R5", "pop empty status", statusFlags, 8'hC0);
    txPush(10'h055);
    check("R5", "head after ignored pop", engTxData, 10'h055);
    txPop(d);
  endtask

  task automatic t_rx_thr();
    logic [7:0] d;
    int n;
    setThr(4'd3);
    check("R8", "thr readback", thrValue, 3);
    for (int i = 0; i < 3; i++) rxPush(8'hA0 + 8'(i));
    check("R8", "3 bytes no irq", irqRxFull, 0);
    check("R3", "3 bytes occ", rxOcc, 2);
    rxPush(8'hA3);
    check("R8", "4 bytes irq", irqRxFull, 1);
    for (int i = 4; i < 16; i++) rxPush(8'hA0 + 8'(i));
    check("R4", "rx full status", statusFlags, 8'hA0);
    rxPush(8'hFF);
    check("R5", "rx push to full occ", rxOcc, 15);
    n = 0;
    while (!statusFlags[6] && n < 40) begin
      rxRead(d);
      check("R2", "rx order", d, 8'hA0 + 8'(n));
      n++;
    end
    check("R10", "drain count", n, 16);
    rxRead(d);
    check("R5", "read empty status", statusFlags, 8'hC0);
    setThr(4'd0);
    rxPush(8'h5A);
    check("R8", "thr 0 one byte", irqRxFull, 1);
    rxRead(d);
    check("R2", "rx single", d, 8'h5A);
  endtask

  task automatic t_simul();
    logic [9:0] d;
    txPush(10'h011);
    txPush(10'h022);
    d = engTxData;
    txWrEn = 1'b1; txWrData = 10'h033; engTxPop = 1'b1; tick();
    txWrEn = 1'b0; engTxPop = 1'b0;
    check("R6", "mid push+pop head", d, 10'h011);
    check("R6", "mid push+pop occ", txOcc, 1);
    txPop(d); check("R6", "mid order 1", d, 10'h022);
    txPop(d); check("R6", "mid order 2", d, 10'h033);
    txWrEn = 1'b1; txWrData = 10'h044; engTxPop = 1'b1; tick();
    txWrEn = 1'b0; engTxPop = 1'b0;
    check("R6", "empty push+pop not empty", statusFlags[7], 0);
    check("R6", "empty push+pop occ", txOcc, 0);
    txPop(d); check("R6", "empty push+pop data", d, 10'h044);
    for (int i = 0; i < 16; i++) txPush(10'h100 + 10'(i));
    txWrEn = 1'b1; txWrData = 10'h3EE; engTxPop = 1'b1; tick();
    txWrEn = 1'b0; engTxPop = 1'b0;
    check("R6", "full push+pop occ", txOcc, 14);
    for (int i = 1; i < 16; i++) begin
      txPop(d);
      check("R6", "full push+pop order", d, 10'h100 + 10'(i));
    end
    check("R6", "dropped word absent", statusFlags[7], 1);
  endtask

  task automatic t_txrst();
    logic [9:0] d;
    logic [7:0] b;
    for (int i = 0; i < 5; i++) txPush(10'h060 + 10'(i));
    rxPush(8'h71);
    rxPush(8'h72);
    ctlWrite(1'b1);
    check("R7", "flush empties tx", statusFlags[7], 1);
    check("R7", "flush tx occ", txOcc, 0);
    check("R7", "rx untouched", rxOcc, 1);
    txPush(10'h077);
    check("R7", "push while held", statusFlags[7], 1);
    ctlWrite(1'b0);
    txPush(10'h088);
    check("R7", "push after release", statusFlags[7], 0);
    check("R7", "occ after release", txOcc, 0);
    txPop(d);
    check("R7", "stale words gone", d, 10'h088);
    rxRead(b); check("R7", "rx kept 1", b, 8'h71);
    rxRead(b); check("R7", "rx kept 2", b, 8'h72);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_tx_fill();
    t_rx_thr();
    t_simul();
    t_txrst();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule